// File: doc/BRIEF.md
# Two-Wire Bus Slave Controller

This block is the slave side of an I2C-compatible two-wire serial interface. It watches the clock (SCL) and data (SDA) lines through synchronizers and finds START and STOP conditions. After a START it collects an address byte and compares the top seven bits with a programmed address. When the address matches, it acknowledges. Then it either collects the bytes written by the bus master, or it sends bytes to the master during a read.

The control settings arrive as static input fields that a surrounding register would drive. They are: a slave enable, an address-length selector (only the 7-bit setting works), a transmit-data-valid gate, a not-acknowledge request and a general-call enable. Bytes for reads come from a shared transmit FIFO through an avail/pop handshake. That FIFO can also hold data meant for a master engine, so the valid gate decides whether the slave may use it. When the slave has no usable data for a read, it holds SCL low until data arrives or the slave is disabled.

Both bus lines are open-drain. Each output of the block is a pull-low enable, and the bus is released when the output is 0.

Top module: `i2c_slave_ctl`

## Requirements
- R1: While reset is asserted, and right after it, both pull-low outputs are 0 and the received-byte strobe is 0.
- R2: While the enable input is 0, a START followed by the block's own address gets no acknowledge (SDA stays released in the acknowledge slot), and no byte is delivered.
- R3: After a START, an address byte whose upper seven bits equal the programmed address is acknowledged: SDA is pulled low during the ninth clock. An address byte that does not match is not acknowledged, and the block ignores the bus until the next START.
- R4: In a write (address bit 0 = 0), each data byte is shifted in MSB first and presented on the received-byte output with a strobe that lasts exactly one clock. Bytes are delivered in bus order and acknowledged.
- R5: When the not-acknowledge input is 1, each received data byte is still delivered with a strobe, but its acknowledge slot is left released (NACK).
- R6: When general-call enable is 1, address byte 0x00 (address 0, write) is acknowledged. When it is 0, that byte is not acknowledged. Byte 0x01 (address 0, read) is never acknowledged as a general call.
- R7: In a read (address bit 0 = 1), each byte is taken from the FIFO head with exactly one pop and driven MSB first, one bit per SCL period.
- R8: During a read, the block pops the FIFO only when both the data-valid input and the FIFO-available input are 1. If either is 0 when a byte is needed, the block holds SCL low and does not pop until both are 1.
- R9: Clearing the enable during a transfer releases SCL and SDA one clock later. The byte in progress is not acknowledged and not delivered. Clearing the enable wins over data becoming valid in the same cycle, so no pop occurs.
- R10: A repeated START (START with no STOP before it) restarts address matching. The new address byte is judged on its own.
- R11: While the address-length input is 1 (the reserved setting), the block stays passive: it acknowledges nothing and releases both lines.
- R12: The block changes its SDA drive only while SCL is low. The one exception is the release forced by clearing the enable.
- R13: When the master NACKs a read byte, the block loads no further byte and pops nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| ctl_enable | input | 1 | Slave enable |
| ctl_own_addr | input | 7 | Programmed 7-bit slave address |
| ctl_addr_long | input | 1 | Address-length select; must be 0, 1 is reserved |
| ctl_tx_valid | input | 1 | FIFO contents may be used for slave reads |
| ctl_nak | input | 1 | Answer received data bytes with NACK |
| ctl_gcall | input | 1 | Respond to the general-call address |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_avail | input | 1 | Transmit FIFO holds at least one entry |
| txf_pop | output | 1 | One-clock pop of the FIFO head |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock strobe: rx_byte is new |

## Verification
The enable-clear abort and the release of a stretched clock can arrive in the same cycle. The bench provokes this by starting a read while data-valid is 0, so SCL is held. Then, at a single clock edge, it raises data-valid and clears the enable. The result is judged at the ports: SCL must be free one clock later, and the FIFO pop count must not change, because the abort takes priority over the load. The rule on SDA changes is also judged on every cycle of the run. The bench watches for any change of the SDA drive while the SCL line is high, so transitions from acknowledge to data and from stretch to data are covered.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_RX,
        S_RACK,
        S_TX,
        S_TACK,
        S_WAIT,
        S_SETUP
    } slv_state_e;

endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = STAGES * W;

    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CW-W-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CW-1 -: W];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two stages");
    end
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

    // SCL edges and bus conditions are mutually exclusive in any cycle
    p_edge_cond_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise || scl_fall) |-> !(start_det || stop_det));
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_addr_long,
    input  logic              cfg_tx_valid,
    input  logic              cfg_nak,
    input  logic              cfg_gcall,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_stb,
    output logic              sda_oe,
    output logic              scl_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        slv_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              rw;
        logic              hi;
        logic              mack;
        logic              sda_oe;
        logic              scl_oe;
        logic [DATA_W-1:0] rx_data;
        logic              rx_stb;
        logic              pop;
    } eng_t;

    eng_t n_d, n_q;

    logic act;
    logic tx_ready;
    logic addr_hit;

    assign act      = cfg_enable & ~cfg_addr_long;
    assign tx_ready = cfg_tx_valid & tx_avail;
    assign addr_hit = (n_q.sh[DATA_W-1 -: ADDR_W] == cfg_addr)
                    || (cfg_gcall && (n_q.sh == '0));

    always_comb begin
        n_d        = n_q;
        n_d.rx_stb = 1'b0;
        n_d.pop    = 1'b0;
        if (!act || stop_det) begin
            n_d.state  = S_IDLE;
            n_d.sda_oe = 1'b0;
            n_d.scl_oe = 1'b0;
            n_d.hi     = 1'b0;
        end else if (start_det) begin
            n_d.state  = S_ADDR;
            n_d.cnt    = '0;
            n_d.sda_oe = 1'b0;
            n_d.scl_oe = 1'b0;
            n_d.hi     = 1'b0;
        end else begin
            unique case (n_q.state)
                S_IDLE: begin
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        n_d.sh  = {n_q.sh[DATA_W-2:0], sda_s};
                        n_d.cnt = n_q.cnt + 1'b1;
                    end
                    if (scl_fall && n_q.cnt == LAST) begin
                        if (addr_hit) begin
                            n_d.state  = S_AACK;
                            n_d.sda_oe = 1'b1;
                            n_d.hi     = 1'b0;
                            n_d.rw     = n_q.sh[0];
                        end else begin
                            n_d.state = S_IDLE;
                        end
                    end
                end
                S_AACK: begin
                    if (scl_rise) n_d.hi = 1'b1;
                    if (scl_fall && n_q.hi) begin
                        n_d.hi  = 1'b0;
                        n_d.cnt = '0;
                        if (!n_q.rw) begin
                            n_d.state  = S_RX;
                            n_d.sda_oe = 1'b0;
                        end else if (tx_ready) begin
                            n_d.sh     = tx_data;
                            n_d.pop    = 1'b1;
                            n_d.sda_oe = ~tx_data[MSB];
                            n_d.state  = S_TX;
                        end else begin
                            n_d.state  = S_WAIT;
                            n_d.sda_oe = 1'b0;
                            n_d.scl_oe = 1'b1;
                        end
                    end
                end
                S_RX: begin
                    if (scl_rise) begin
                        n_d.sh  = {n_q.sh[DATA_W-2:0], sda_s};
                        n_d.cnt = n_q.cnt + 1'b1;
                    end
                    if (scl_fall && n_q.cnt == LAST) begin
                        n_d.rx_data = n_q.sh;
                        n_d.rx_stb  = 1'b1;
                        n_d.state   = S_RACK;
                        n_d.sda_oe  = ~cfg_nak;
                        n_d.hi      = 1'b0;
                    end
                end
                S_RACK: begin
                    if (scl_rise) n_d.hi = 1'b1;
                    if (scl_fall && n_q.hi) begin
                        n_d.state  = S_RX;
                        n_d.cnt    = '0;
                        n_d.sda_oe = 1'b0;
                        n_d.hi     = 1'b0;
                    end
                end
                S_TX: begin
                    if (scl_rise) n_d.cnt = n_q.cnt + 1'b1;
                    if (scl_fall) begin
                        if (n_q.cnt == LAST) begin
                            n_d.state  = S_TACK;
                            n_d.sda_oe = 1'b0;
                            n_d.hi     = 1'b0;
                        end else begin
                            n_d.sh     = {n_q.sh[DATA_W-2:0], 1'b0};
                            n_d.sda_oe = ~n_q.sh[DATA_W-2];
                        end
                    end
                end
                S_TACK: begin
                    if (scl_rise) begin
                        n_d.mack = ~sda_s;
                        n_d.hi   = 1'b1;
                    end
                    if (scl_fall && n_q.hi) begin
                        n_d.hi  = 1'b0;
                        n_d.cnt = '0;
                        if (!n_q.mack) begin
                            n_d.state = S_IDLE;
                        end else if (tx_ready) begin
                            n_d.sh     = tx_data;
                            n_d.pop    = 1'b1;
                            n_d.sda_oe = ~tx_data[MSB];
                            n_d.state  = S_TX;
                        end else begin
                            n_d.state  = S_WAIT;
                            n_d.scl_oe = 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    n_d.scl_oe = 1'b1;
                    if (tx_ready) begin
                        n_d.sh     = tx_data;
                        n_d.pop    = 1'b1;
                        n_d.sda_oe = ~tx_data[MSB];
                        n_d.state  = S_SETUP;
                    end
                end
                S_SETUP: begin
                    n_d.scl_oe = 1'b0;
                    n_d.state  = S_TX;
                end
                default: begin
                    n_d.state  = S_IDLE;
                    n_d.sda_oe = 1'b0;
                    n_d.scl_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{state: S_IDLE, default: '0};
        end else begin
            n_q <= n_d;
        end
    end

    assign tx_pop  = n_q.pop;
    assign rx_data = n_q.rx_data;
    assign rx_stb  = n_q.rx_stb;
    assign sda_oe  = n_q.sda_oe;
    assign scl_oe  = n_q.scl_oe;

    // SDA drive moves only while the synchronized SCL is low (enabled operation)
    p_sda_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && $past(act)) |-> !$past(scl_s));

    // A disabled slave releases both lines on the next clock
    p_release_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!sda_oe && !scl_oe));

    // Reserved address-length setting keeps the block off the bus
    p_long_addr_passive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_long |=> (!sda_oe && !scl_oe && !rx_stb));

    // A pop needs both data-valid and FIFO-available in the deciding cycle
    p_pop_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> $past(cfg_tx_valid && tx_avail));

    // Received-byte strobe is a single-clock pulse
    p_rx_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);
endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic              ctl_enable,
    input  logic [ADDR_W-1:0] ctl_own_addr,
    input  logic              ctl_addr_long,
    input  logic              ctl_tx_valid,
    input  logic              ctl_nak,
    input  logic              ctl_gcall,
    input  logic [DATA_W-1:0] txf_data,
    input  logic              txf_avail,
    output logic              txf_pop,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic [1:0] bus_sync;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_slv_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_sync)
    );

    assign scl_s = bus_sync[1];
    assign sda_s = bus_sync[0];

    i2c_slv_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slv_engine #(.DATA_W(DATA_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_s         (scl_s),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .cfg_enable    (ctl_enable),
        .cfg_addr      (ctl_own_addr),
        .cfg_addr_long (ctl_addr_long),
        .cfg_tx_valid  (ctl_tx_valid),
        .cfg_nak       (ctl_nak),
        .cfg_gcall     (ctl_gcall),
        .tx_data       (txf_data),
        .tx_avail      (txf_avail),
        .tx_pop        (txf_pop),
        .rx_data       (rx_byte),
        .rx_stb        (rx_valid),
        .sda_oe        (sda_pull_o),
        .scl_oe        (scl_pull_o)
    );
endmodule

// File: tb/i2c_slave_ctl_tb_top.sv
module i2c_slave_ctl_tb_top;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_pull, sda_pull;
    logic en = 1'b0, alen = 1'b0, txv = 1'b0, nak = 1'b0, gc = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_avail = 1'b0;
    logic tx_pop;
    logic [7:0] rx_byte;
    logic rx_valid;
    wire scl_line = scl_m & ~scl_pull;
    wire sda_line = sda_m & ~sda_pull;

    int checks = 0, fails = 0, pops = 0;
    logic [7:0] exp_q[$];
    logic [7:0] txq[$];

    always #5 clk = ~clk;

    i2c_slave_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .ctl_enable(en), .ctl_own_addr(OWN), .ctl_addr_long(alen),
        .ctl_tx_valid(txv), .ctl_nak(nak), .ctl_gcall(gc),
        .txf_data(tx_data), .txf_avail(tx_avail), .txf_pop(tx_pop),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor, FIFO model and SDA rule watcher
    logic sda_prev = 1'b0, en_prev = 1'b0;
    always @(negedge clk) begin
        if (rx_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", rx_byte, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_byte == e, "R4 received byte", rx_byte, e);
            end
        end
        if (tx_pop) begin
            if (txq.size() != 0) void'(txq.pop_front());
            pops++;
        end
        tx_avail = (txq.size() != 0);
        tx_data  = tx_avail ? txq[0] : 8'h00;
        if (rst_n && (sda_pull != sda_prev) && en && en_prev)
            chk(scl_line == 1'b0, "R12 SDA moved with SCL high", scl_line, 0);
        sda_prev = sda_pull;
        en_prev  = en;
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wcyc(H); scl_m = 1'b1; wait (scl_line === 1'b1); wcyc(H);
        sda_m = 1'b0; wcyc(H); scl_m = 1'b0; wcyc(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wcyc(H); scl_m = 1'b1; wait (scl_line === 1'b1); wcyc(H);
        sda_m = 1'b1; wcyc(H);
    endtask

    task automatic m_clock(output logic smp);
        wcyc(H); scl_m = 1'b1; wait (scl_line === 1'b1); wcyc(H);
        smp = sda_line; scl_m = 1'b0; wcyc(2);
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            m_clock(s);
        end
        sda_m = 1'b1;
        m_clock(ack);
        wcyc(H);
    endtask

    task automatic m_read(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1;
            m_clock(s);
            d[i] = s;
        end
        sda_m = mack;
        m_clock(s);
        wcyc(H);
        sda_m = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic a;
        logic [7:0] d;
        int p0;
        wcyc(4);
        chk(scl_pull == 0 && sda_pull == 0 && rx_valid == 0, "R1 outputs in reset",
            {scl_pull, sda_pull, rx_valid}, 0);
        rst_n = 1'b1;
        wcyc(4);
        chk(scl_pull == 0 && sda_pull == 0 && rx_valid == 0, "R1 outputs after reset",
            {scl_pull, sda_pull, rx_valid}, 0);

        // R2: disabled
        m_start(); m_write({OWN, 1'b0}, a); m_stop();
        chk(a == 1'b1, "R2 disabled address ack", a, 1);
        en = 1'b1;

        // R3/R4: matching write, two bytes
        m_start(); m_write({OWN, 1'b0}, a);
        chk(a == 1'b0, "R3 own address acked", a, 0);
        exp_q.push_back(8'hA5); m_write(8'hA5, a);
        chk(a == 1'b0, "R4 byte A5 acked", a, 0);
        exp_q.push_back(8'h3C); m_write(8'h3C, a);
        chk(a == 1'b0, "R4 byte 3C acked", a, 0);
        m_stop();

        // R3: mismatch, followed byte ignored
        m_start(); m_write({7'h11, 1'b0}, a);
        chk(a == 1'b1, "R3 foreign address not acked", a, 1);
        m_write(8'h99, a);
        chk(a == 1'b1, "R3 ignored after mismatch", a, 1);
        m_stop();

        // R5: NAK request
        nak = 1'b1;
        m_start(); m_write({OWN, 1'b0}, a);
        chk(a == 1'b0, "R5 address still acked", a, 0);
        exp_q.push_back(8'h5A); m_write(8'h5A, a);
        chk(a == 1'b1, "R5 data byte nacked", a, 1);
        m_stop(); nak = 1'b0;

        // R6: general call
        m_start(); m_write(8'h00, a); m_stop();
        chk(a == 1'b1, "R6 general call off", a, 1);
        gc = 1'b1;
        m_start(); m_write(8'h00, a);
        chk(a == 1'b0, "R6 general call on", a, 0);
        exp_q.push_back(8'hE1); m_write(8'hE1, a); m_stop();
        m_start(); m_write(8'h01, a); m_stop();
        chk(a == 1'b1, "R6 general call read refused", a, 1);
        gc = 1'b0;

        // R7/R13: read two bytes, third entry stays
        txq.push_back(8'hC3); txq.push_back(8'h96); txq.push_back(8'h77);
        txv = 1'b1; wcyc(2); p0 = pops;
        m_start(); m_write({OWN, 1'b1}, a);
        chk(a == 1'b0, "R7 read address acked", a, 0);
        m_read(1'b0, d); chk(d == 8'hC3, "R7 first read byte", d, 8'hC3);
        m_read(1'b1, d); chk(d == 8'h96, "R7 second read byte", d, 8'h96);
        m_stop(); wcyc(8);
        chk(pops - p0 == 2, "R13 pops after master NACK", pops - p0, 2);

        // R8: stretch while data not valid
        txv = 1'b0; p0 = pops;
        m_start(); m_write({OWN, 1'b1}, a);
        fork
            m_read(1'b1, d);
            begin
                wcyc(20 * H);
                chk(scl_line == 1'b0, "R8 SCL held low", scl_line, 0);
                chk(pops == p0, "R8 no pop while invalid", pops - p0, 0);
                txv = 1'b1;
            end
        join
        chk(d == 8'h77, "R8 byte after stretch", d, 8'h77);
        m_stop(); txv = 1'b0;

        // R9: abort mid write
        m_start(); m_write({OWN, 1'b0}, a);
        fork
            m_write(8'h55, a);
            begin
                wcyc(4 * (2 * H + 4));
                en = 1'b0; wcyc(2);
                chk(sda_pull == 0 && scl_pull == 0, "R9 lines released", {scl_pull, sda_pull}, 0);
            end
        join
        chk(a == 1'b1, "R9 aborted byte not acked", a, 1);
        en = 1'b1; m_stop();

        // R9: abort wins over valid arriving in the same cycle
        txq.push_back(8'h66); txv = 1'b0; wcyc(2); p0 = pops;
        m_start(); m_write({OWN, 1'b1}, a);
        fork
            m_read(1'b1, d);
            begin
                wcyc(10 * H);
                chk(scl_line == 1'b0, "R9 stretched before abort", scl_line, 0);
                txv = 1'b1; en = 1'b0; wcyc(2);
                chk(scl_pull == 1'b0, "R9 stretch released", scl_pull, 0);
                chk(pops == p0, "R9 no pop on abort", pops - p0, 0);
            end
        join
        txv = 1'b0; en = 1'b1; m_stop(); txq.delete();

        // R10: repeated START
        m_start(); m_write({OWN, 1'b0}, a);
        exp_q.push_back(8'h12); m_write(8'h12, a);
        m_start(); m_write({OWN, 1'b0}, a);
        chk(a == 1'b0, "R10 restart own address", a, 0);
        exp_q.push_back(8'h34); m_write(8'h34, a);
        m_start(); m_write({7'h22, 1'b0}, a);
        chk(a == 1'b1, "R10 restart foreign address", a, 1);
        m_stop();

        // R11: reserved address length
        alen = 1'b1;
        m_start(); m_write({OWN, 1'b0}, a); m_stop();
        chk(a == 1'b1, "R11 reserved length passive", a, 1);
        alen = 1'b0;

        wcyc(10);
        chk(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule